// File: doc/BRIEF.md
# Multi-Address Two-Wire Bus Target

This block is the target side of a two-wire serial bus controller. It runs on a system clock that is much faster than the bus clock. It samples the clock line and the data line through a short synchronizer and detects start, repeated start and stop conditions. It then decodes the first byte of each transfer as a 7-bit address followed by a direction bit.

The address is compared against a small table. Each entry in the table has its own enable bit, a read-event mask bit and a write-event mask bit. A matching transfer is acknowledged. Write bytes are handed out one at a time, each tagged with the index of the matching entry. Read bytes are taken from a reply stream supplied by the surrounding logic. When no reply byte is ready, the target holds the clock line low until one arrives. A separate switch decides whether the broadcast (all-zero) write address is acknowledged.

Top module: `i2c_multi_target`

## Requirements
- R1: A start or repeated start, seen as a falling data line while the clock line is high, restarts address reception from its first bit and discards any partly received byte. A stop, seen as a rising data line while the clock line is high, ends the transfer.
- R2: The first byte after a start holds the address in its seven upper bits, most significant bit first, and the direction in bit 0 (0 = write, 1 = read). When several enabled entries hold the received address, the entry with the lowest index is selected. The target then pulls the data line low through the ninth clock. An address that matches no enabled entry, and is not an accepted broadcast, gets no acknowledge.
- R3: Any 7-bit value placed in the table is matched, including reserved values such as 0x78. Disabled entries never match.
- R4: Address 0x00 with direction 0 is acknowledged only while `gc_enable` is 1 and no enabled entry holds 0x00. Its write bytes carry `wr_gcall` = 1 and `wr_entry` = 0. Address 0x00 with direction 1 is never acknowledged as a broadcast.
- R5: Every write byte after an acknowledged write address is acknowledged. It appears once, as a one-cycle `wr_valid` pulse carrying the byte and the selected entry index.
- R6: `ev_write` pulses once when a write address is acknowledged for an entry whose write-event mask bit is 1. `ev_read` pulses once when a read address is acknowledged for an entry whose read-event mask bit is 1. `ev_entry` carries the entry index. The broadcast address raises no event.
- R7: Read bytes are sent most significant bit first, in the order of the reply stream. `rd_pop` pulses once for each byte taken.
- R8: After the bus controller answers a read byte with no acknowledge, the target drives neither line until the next start or stop. Extra clock pulses during that time read as all ones.
- R9: When a read byte is due and `rd_valid` is 0, the target holds the clock line low from the falling clock edge onward. It releases the line only after it has loaded a reply byte and set up its first bit.
- R10: After reset, both line drivers are released and no data or event pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Level of the bus clock line |
| sda_in | input | 1 | Level of the bus data line |
| scl_pull | output | 1 | 1 pulls the clock line low (stretch) |
| sda_pull | output | 1 | 1 pulls the data line low |
| gc_enable | input | 1 | Acknowledge the broadcast write address |
| addr_table | input | ENTRIES*7 | Packed 7-bit addresses, entry i at bits [7i+6:7i] |
| entry_enable | input | ENTRIES | Per-entry enable |
| rd_evt_mask | input | ENTRIES | Per-entry read-event enable |
| wr_evt_mask | input | ENTRIES | Per-entry write-event enable |
| wr_valid | output | 1 | One-cycle pulse: a write byte is presented |
| wr_data | output | 8 | Received write byte |
| wr_entry | output | IW | Entry index of the write byte |
| wr_gcall | output | 1 | Write byte belongs to a broadcast transfer |
| rd_valid | input | 1 | Reply byte available |
| rd_data | input | 8 | Reply byte |
| rd_pop | output | 1 | One-cycle pulse: reply byte taken |
| ev_read | output | 1 | Read-start event pulse |
| ev_write | output | 1 | Write-start event pulse |
| ev_entry | output | IW | Entry index of the event |

## Verification
The event pulse and the start of address acknowledge fall in the same system cycle: a matched address raises the acknowledge drive and the entry's event together. A sweep over all 128 addresses in both directions judges each acknowledge, event count and entry index against a table match computed in the bench. Clock stretching and the release of a reply byte can also coincide with a repeated start, so a write followed by a repeated-start read to the same entry is checked for one event of each kind and an uncorrupted reply.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_DEC,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_DEC,
    ST_WR_ACK,
    ST_RD_BITS,
    ST_RD_ACK,
    ST_STRETCH,
    ST_UNSTRETCH,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // data edges only count as conditions while the clock stays high
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

  a_r1_cond_while_high: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |-> $past(scl_pipe[STAGES-1]));
endmodule

// File: rtl/i2ct_addr_lookup.sv
module i2ct_addr_lookup #(
  parameter int N  = 4,
  parameter int AW = 7,
  parameter int IW = 2
) (
  input  logic [N*AW-1:0] table_flat,
  input  logic [N-1:0]    entry_en,
  input  logic [AW-1:0]   addr_q,
  output logic            hit,
  output logic [IW-1:0]   hit_idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = entry_en[g] && (table_flat[g*AW +: AW] == addr_q);
  end

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              gc_en,
  input  logic [N-1:0]      rd_mask,
  input  logic [N-1:0]      wr_mask,
  input  logic              hit,
  input  logic [IW-1:0]     hit_idx,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_pop,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IW-1:0]     wr_idx,
  output logic              wr_gc,
  output logic              ev_rd,
  output logic              ev_wr,
  output logic [IW-1:0]     ev_idx
);
  tgt_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [IW-1:0]     cur_idx;
  logic              cur_gc;
  logic              cur_rw;
  logic              mst_ack;
  logic              addr_ok;

  assign rx_byte = rx_sh;
  assign addr_ok = hit || (gc_en && rx_sh == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      cur_idx  <= '0;
      cur_gc   <= 1'b0;
      cur_rw   <= 1'b0;
      mst_ack  <= 1'b0;
      sda_oe   <= 1'b0;
      scl_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_idx   <= '0;
      wr_gc    <= 1'b0;
      ev_rd    <= 1'b0;
      ev_wr    <= 1'b0;
      ev_idx   <= '0;
      rd_pop   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      ev_rd    <= 1'b0;
      ev_wr    <= 1'b0;
      rd_pop   <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        scl_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            if (bit_cnt == 4'd7) state <= ST_ADDR_DEC;
            else bit_cnt <= bit_cnt + 4'd1;
          end
          ST_ADDR_DEC: if (scl_fall) begin
            if (addr_ok) begin
              sda_oe  <= 1'b1;
              state   <= ST_ADDR_ACK;
              cur_idx <= hit ? hit_idx : '0;
              cur_gc  <= !hit;
              cur_rw  <= rx_sh[0];
              ev_idx  <= hit_idx;
              ev_rd   <= hit && rx_sh[0] && rd_mask[hit_idx];
              ev_wr   <= hit && !rx_sh[0] && wr_mask[hit_idx];
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ADDR_ACK, ST_RD_ACK: begin
            if (scl_rise && state == ST_RD_ACK) mst_ack <= ~sda_lvl;
            if (scl_fall) begin
              bit_cnt <= '0;
              if (state == ST_ADDR_ACK && !cur_rw) begin
                sda_oe <= 1'b0;
                state  <= ST_WR_BITS;
              end else if (state == ST_RD_ACK && !mst_ack) begin
                sda_oe <= 1'b0;
                state  <= ST_IGNORE;
              end else if (rd_valid) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                rd_pop <= 1'b1;
                state  <= ST_RD_BITS;
              end else begin
                sda_oe <= 1'b0;
                scl_oe <= 1'b1;
                state  <= ST_STRETCH;
              end
            end
          end
          ST_STRETCH: if (rd_valid) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
            rd_pop <= 1'b1;
            state  <= ST_UNSTRETCH;
          end
          ST_UNSTRETCH: begin
            scl_oe <= 1'b0;
            state  <= ST_RD_BITS;
          end
          ST_RD_BITS: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                sda_oe <= ~tx_sh[3'd7 - bit_cnt[2:0]];
              end
            end
          end
          ST_WR_BITS: if (scl_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            if (bit_cnt == 4'd7) state <= ST_WR_DEC;
            else bit_cnt <= bit_cnt + 4'd1;
          end
          ST_WR_DEC: if (scl_fall) begin
            sda_oe   <= 1'b1;
            wr_valid <= 1'b1;
            wr_data  <= rx_sh;
            wr_idx   <= cur_idx;
            wr_gc    <= cur_gc;
            state    <= ST_WR_ACK;
          end
          ST_WR_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WR_BITS;
          end
          default: ;
        endcase
      end
    end
  end

  a_r5_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  a_r7_pop_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> !rd_pop);
  a_r6_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ev_rd && ev_wr));
  a_r2_drive_in_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
  a_r9_stretch_in_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !scl_lvl);
  a_r8_quiet_after_nack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> (!sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_multi_target.sv
module i2c_multi_target #(
  parameter int ENTRIES     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 scl_pull,
  output logic                 sda_pull,
  input  logic                 gc_enable,
  input  logic [ENTRIES*7-1:0] addr_table,
  input  logic [ENTRIES-1:0]   entry_enable,
  input  logic [ENTRIES-1:0]   rd_evt_mask,
  input  logic [ENTRIES-1:0]   wr_evt_mask,
  output logic                 wr_valid,
  output logic [7:0]           wr_data,
  output logic [IW-1:0]        wr_entry,
  output logic                 wr_gcall,
  input  logic                 rd_valid,
  input  logic [7:0]           rd_data,
  output logic                 rd_pop,
  output logic                 ev_read,
  output logic                 ev_write,
  output logic [IW-1:0]        ev_entry
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic hit;
  logic [IW-1:0] hit_idx;
  logic [7:0] rx_byte;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_addr_lookup #(.N(ENTRIES), .AW(7), .IW(IW)) u_lookup (
    .table_flat(addr_table), .entry_en(entry_enable),
    .addr_q(rx_byte[7:1]), .hit(hit), .hit_idx(hit_idx)
  );

  i2ct_ctrl #(.N(ENTRIES), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .gc_en(gc_enable), .rd_mask(rd_evt_mask),
    .wr_mask(wr_evt_mask), .hit(hit), .hit_idx(hit_idx), .rx_byte(rx_byte),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_pop(rd_pop),
    .sda_oe(sda_pull), .scl_oe(scl_pull), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_idx(wr_entry), .wr_gc(wr_gcall),
    .ev_rd(ev_read), .ev_wr(ev_write), .ev_idx(ev_entry)
  );

  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!scl_pull && !sda_pull && !wr_valid && !ev_read && !ev_write));
endmodule

// File: tb/i2c_multi_target_tb.sv
module i2c_multi_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int N = 4;
  localparam logic [6:0] TAB [N] = '{7'h78, 7'h21, 7'h21, 7'h50};
  localparam logic [N-1:0] EN = 4'b0111;
  localparam logic [N-1:0] WRM = 4'b0011;
  localparam logic [N-1:0] RDM = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic gc_en = 1'b1;
  logic rd_valid = 1'b1;
  logic [7:0] reply_mem [4];
  logic [1:0] rd_ptr = '0;
  wire scl_pull, sda_pull;
  wire scl_bus = !(m_scl_low || scl_pull);
  wire sda_bus = !(m_sda_low || sda_pull);
  wire wr_valid, wr_gcall, rd_pop, ev_read, ev_write;
  wire [7:0] wr_data;
  wire [1:0] wr_entry, ev_entry;
  wire [7:0] rd_data = reply_mem[rd_ptr];
  logic [N*7-1:0] tab_flat;

  int n_checks = 0, n_fail = 0;
  int n_wr = 0, n_evr = 0, n_evw = 0, n_pop = 0;
  logic [7:0] last_wr = '0;
  logic [1:0] last_wr_entry = '0, last_ev_entry = '0;
  logic last_gc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < N; i++) tab_flat[i*7 +: 7] = TAB[i];

  i2c_multi_target #(.ENTRIES(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .gc_enable(gc_en),
    .addr_table(tab_flat), .entry_enable(EN), .rd_evt_mask(RDM),
    .wr_evt_mask(WRM), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_entry(wr_entry), .wr_gcall(wr_gcall), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_pop(rd_pop), .ev_read(ev_read),
    .ev_write(ev_write), .ev_entry(ev_entry)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) begin
        n_wr++; last_wr = wr_data; last_wr_entry = wr_entry; last_gc = wr_gcall;
      end
      if (ev_read) begin n_evr++; last_ev_entry = ev_entry; end
      if (ev_write) begin n_evw++; last_ev_entry = ev_entry; end
      if (rd_pop) begin n_pop++; rd_ptr <= rd_ptr + 2'd1; end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; tick(HALF);
    m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b1; tick(HALF);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
    m_sda_low = 1'b0; tick(HALF);
  endtask

  task automatic m_bit(input logic b, output logic got);
    m_sda_low = !b; tick(HALF);
    m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
    got = sda_bus;
    m_scl_low = 1'b1; tick(2);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) m_bit(b[i], g);
    m_bit(1'b1, g);
    acked = !g;
  endtask

  task automatic m_rd_byte(input logic ack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, g); d[i] = g; end
    m_bit(!ack, g);
  endtask

  function automatic int exp_entry(input int a);
    for (int i = 0; i < N; i++) if (EN[i] && TAB[i] == 7'(a)) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, e0, r0, p0;
    for (int i = 0; i < 4; i++) reply_mem[i] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(3);
    // R10: quiet after reset
    check(!scl_pull && !sda_pull, "R10", "drivers", {scl_pull, sda_pull}, 0);
    check(n_wr == 0 && n_evr == 0 && n_evw == 0, "R10", "pulses", n_wr + n_evr + n_evw, 0);

    // write sweep: R2, R3, R4, R5, R6
    for (int a = 0; a < 128; a++) begin
      int ei;
      bit exp_ack;
      logic [7:0] wb;
      string tag;
      ei = exp_entry(a);
      exp_ack = (ei >= 0) || (a == 0 && gc_en);
      tag = (a == 8'h78) ? "R3" : ((a == 0) ? "R4" : "R2");
      wb = 8'(a) ^ 8'hA5;
      w0 = n_wr; e0 = n_evw;
      m_start();
      m_byte({7'(a), 1'b0}, ack);
      check(ack == exp_ack, tag, "write addr ack", ack, exp_ack);
      if (ack) begin
        m_byte(wb, ack);
        check(ack, "R5", "data ack", ack, 1);
      end
      m_stop();
      tick(4);
      check(n_wr - w0 == (exp_ack ? 1 : 0), "R5", "write pulses", n_wr - w0, exp_ack);
      if (exp_ack) begin
        check(last_wr == wb, "R5", "write data", last_wr, wb);
        check(last_wr_entry == ((ei >= 0) ? ei : 0), tag, "write entry", last_wr_entry, (ei >= 0) ? ei : 0);
        check(last_gc == (ei < 0), "R4", "gcall flag", last_gc, ei < 0);
      end
      check(n_evw - e0 == ((ei >= 0 && WRM[ei]) ? 1 : 0), "R6", "write event", n_evw - e0, (ei >= 0 && WRM[ei]));
      if (ei >= 0 && WRM[ei]) check(last_ev_entry == ei, "R6", "write event entry", last_ev_entry, ei);
    end

    // read sweep: R2, R4, R6, R7
    for (int a = 0; a < 128; a++) begin
      int ei;
      logic [7:0] expd;
      ei = exp_entry(a);
      expd = 8'(a) ^ 8'h96;
      for (int i = 0; i < 4; i++) reply_mem[i] = expd;
      r0 = n_evr; p0 = n_pop;
      m_start();
      m_byte({7'(a), 1'b1}, ack);
      check(ack == (ei >= 0), (a == 0) ? "R4" : "R2", "read addr ack", ack, ei >= 0);
      if (ack) begin
        m_rd_byte(1'b0, d);
        check(d == expd, "R7", "read byte", d, expd);
      end
      m_stop();
      tick(4);
      check(n_pop - p0 == ((ei >= 0) ? 1 : 0), "R7", "pop count", n_pop - p0, ei >= 0);
      check(n_evr - r0 == ((ei >= 0 && RDM[ei]) ? 1 : 0), "R6", "read event", n_evr - r0, (ei >= 0 && RDM[ei]));
      if (ei >= 0 && RDM[ei]) check(last_ev_entry == ei, "R6", "read event entry", last_ev_entry, ei);
    end

    // R4: broadcast refused when switched off
    gc_en = 1'b0;
    w0 = n_wr;
    m_start(); m_byte(8'h00, ack); m_stop(); tick(4);
    check(!ack, "R4", "gc off ack", ack, 0);
    check(n_wr == w0, "R4", "gc off writes", n_wr - w0, 0);
    gc_en = 1'b1;

    // R7 + R8: multi-byte read in stream order, then silence after NACK
    reply_mem[0] = 8'h3C; reply_mem[1] = 8'hC3; reply_mem[2] = 8'h5A; reply_mem[3] = 8'h81;
    tick(2);
    begin
      logic [7:0] exp0, exp1, exp2;
      exp0 = reply_mem[rd_ptr]; exp1 = reply_mem[rd_ptr + 2'd1]; exp2 = reply_mem[rd_ptr + 2'd2];
      p0 = n_pop;
      m_start(); m_byte({7'h21, 1'b1}, ack);
      check(ack, "R2", "multi read ack", ack, 1);
      m_rd_byte(1'b1, d); check(d == exp0, "R7", "byte 0", d, exp0);
      m_rd_byte(1'b1, d); check(d == exp1, "R7", "byte 1", d, exp1);
      m_rd_byte(1'b0, d); check(d == exp2, "R7", "byte 2", d, exp2);
      m_rd_byte(1'b0, d); check(d == 8'hFF, "R8", "after nack", d, 8'hFF);
      check(!sda_pull && !scl_pull, "R8", "released", {scl_pull, sda_pull}, 0);
      m_stop(); tick(4);
      check(n_pop - p0 == 3, "R7", "pops", n_pop - p0, 3);
    end

    // R9: stretch while no reply byte is ready
    rd_valid = 1'b0;
    for (int i = 0; i < 4; i++) reply_mem[i] = 8'hB7;
    m_start(); m_byte({7'h21, 1'b1}, ack);
    check(ack, "R9", "stretch addr ack", ack, 1);
    fork
      m_rd_byte(1'b0, d);
      begin
        tick(60);
        check(scl_pull == 1'b1, "R9", "holding clock", scl_pull, 1);
        check(scl_bus == 1'b0, "R9", "clock low", scl_bus, 0);
        rd_valid = 1'b1;
      end
    join
    check(d == 8'hB7, "R9", "byte after stretch", d, 8'hB7);
    m_stop(); tick(4);
    check(!scl_pull, "R9", "clock released", scl_pull, 0);

    // R1: write then repeated start into read, same entry
    w0 = n_wr; e0 = n_evw; r0 = n_evr;
    m_start(); m_byte({7'h21, 1'b0}, ack); m_byte(8'h5C, ack);
    m_start(); m_byte({7'h21, 1'b1}, ack);
    check(ack, "R1", "ack after repeated start", ack, 1);
    m_rd_byte(1'b0, d);
    check(d == 8'hB7, "R1", "read after repeated start", d, 8'hB7);
    m_stop(); tick(4);
    check(n_wr - w0 == 1 && last_wr == 8'h5C, "R1", "write before restart", last_wr, 8'h5C);
    check(n_evw - e0 == 1 && n_evr - r0 == 1, "R1", "events both", (n_evw - e0) * 16 + (n_evr - r0), 17);

    // R1: repeated start in the middle of a byte drops the partial byte
    w0 = n_wr;
    m_start(); m_byte({7'h78, 1'b0}, ack);
    begin logic g; m_bit(1'b0, g); m_bit(1'b1, g); m_bit(1'b0, g); end
    m_start(); m_byte({7'h21, 1'b0}, ack);
    check(ack, "R1", "ack after mid-byte restart", ack, 1);
    m_byte(8'h99, ack);
    m_stop(); tick(4);
    check(n_wr - w0 == 1, "R1", "partial dropped", n_wr - w0, 1);
    check(last_wr == 8'h99 && last_wr_entry == 2'd1, "R1", "restart data", last_wr, 8'h99);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule